// File: doc/BRIEF.md
# Registered Eight-Operation Arithmetic Unit

This block is a compact arithmetic-logic unit for unsigned nibble operands. Two 4-bit values and a 3-bit operation code are sampled on a rising clock edge while an input qualifier is high. One cycle later the block presents a 5-bit result together with an output qualifier. The eight operations are: copy of the first operand, sum, difference, integer quotient, remainder, single-bit left shift, single-bit right shift, and a greater-than test. Every result is cut to five bits, and any overflow or underflow is discarded.

The datapath is purely combinational and feeds one output register. Division by zero returns fixed values, so the output is always defined. When no input is qualified, the result register keeps its last value and the output qualifier drops.

Top module: `nib_alu`

## Requirements
- R1: Operation code 3'b000 yields the first operand `opa`, zero-extended to 5 bits.
- R2: Code 3'b001 yields `opa + opb` as a 5-bit value, so the carry appears in bit 4.
- R3: Code 3'b010 yields `(opa - opb) mod 32`. When `opb` is larger than `opa`, this is the 5-bit two's-complement pattern.
- R4: Code 3'b011 yields the integer quotient `opa / opb`. When `opb` is 0 it yields 5'b11111.
- R5: Code 3'b100 yields `opa % opb`. When `opb` is 0 it yields `opa`, zero-extended.
- R6: Code 3'b101 yields `opa << 1` in 5 bits, and code 3'b110 yields `opa >> 1`.
- R7: Code 3'b111 yields 1 in bit 0 when `opa > opb` and 0 otherwise. Bits 4..1 are always 0.
- R8: Inputs sampled at a rising edge with `in_vld` high appear on `res` one cycle later, and `res_vld` is high in that cycle.
- R9: After an edge with `in_vld` low, `res_vld` is 0 and `res` keeps its previous value.
- R10: A synchronous active-high `rst` clears `res` and `res_vld` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Qualifies the operands and the operation code for capture |
| opa | input | 4 | First unsigned operand |
| opb | input | 4 | Second unsigned operand |
| op | input | 3 | Operation code |
| res | output | 5 | Registered result |
| res_vld | output | 1 | High when `res` holds the result of the previous qualified input |

## Verification
Every result is due exactly one rising edge after its inputs are sampled, because only the output register lies between the inputs and `res`. The bench drives inputs after the falling edge and samples `res` and `res_vld` at the next falling edge, which is half a period after the capturing edge. It computes the expected value from the operands it applied and compares it there. Idle cycles check that `res` holds its last value against a copy kept in the bench.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_PASS = 3'b000,
    OP_ADD  = 3'b001,
    OP_SUB  = 3'b010,
    OP_DIV  = 3'b011,
    OP_REM  = 3'b100,
    OP_SHL  = 3'b101,
    OP_SHR  = 3'b110,
    OP_GT   = 3'b111
  } alu_op_e;
endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith #(
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [RW-1:0] sum,
  output logic [RW-1:0] diff,
  output logic [RW-1:0] quo,
  output logic [RW-1:0] rem,
  output logic          b_zero
);
  logic [RW-1:0] ax, bx;
  always_comb begin
    ax     = RW'(a);
    bx     = RW'(b);
    b_zero = (b == '0);
    sum    = ax + bx;
    diff   = ax - bx;
    if (b_zero) begin
      quo = '1;
      rem = ax;
    end else begin
      quo = RW'(a / b);
      rem = RW'(a % b);
    end
  end
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic #(
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [RW-1:0] shl,
  output logic [RW-1:0] shr,
  output logic [RW-1:0] gt
);
  always_comb begin
    shl = RW'(a) << 1;
    shr = RW'(a >> 1);
    gt  = '0;
    gt[0] = (a > b);
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int DW = 4,
  localparam int RW = DW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [OP_W-1:0] op,
  output logic [RW-1:0]   res,
  output logic            res_vld
);
  logic [RW-1:0] sum, diff, quo, rem, shl, shr, gt, nxt;
  logic          b_zero;

  nib_alu_arith #(.DW(DW), .RW(RW)) u_arith (
    .a(opa), .b(opb), .sum(sum), .diff(diff), .quo(quo), .rem(rem), .b_zero(b_zero)
  );

  nib_alu_logic #(.DW(DW), .RW(RW)) u_logic (
    .a(opa), .b(opb), .shl(shl), .shr(shr), .gt(gt)
  );

  always_comb begin
    unique case (alu_op_e'(op))
      OP_PASS: nxt = RW'(opa);
      OP_ADD:  nxt = sum;
      OP_SUB:  nxt = diff;
      OP_DIV:  nxt = quo;
      OP_REM:  nxt = rem;
      OP_SHL:  nxt = shl;
      OP_SHR:  nxt = shr;
      OP_GT:   nxt = gt;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) res <= nxt;
    end
  end
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [2:0]    op,
  input logic [RW-1:0] res,
  input logic          res_vld
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !seen)
    in_vld |=> res_vld); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !seen)
    !in_vld |=> (!res_vld && $stable(res))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res == '0 && !res_vld)); // R10
  AST_GT_BITS: assert property (@(posedge clk) disable iff (rst || !seen)
    (in_vld && op == 3'b111) |=> (res[RW-1:1] == '0)); // R7
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst || !seen)
    (in_vld && op == 3'b011 && opb == '0) |=> (res == '1)); // R4
  AST_PASS: assert property (@(posedge clk) disable iff (rst || !seen)
    (in_vld && op == 3'b000) |=> (res == RW'($past(opa)))); // R1
endmodule

bind nib_alu nib_alu_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
  .op(op), .res(res), .res_vld(res_vld)
);

// File: tb/sim_nib_alu.sv
`timescale 1ns/1ps
module sim_nib_alu;
  logic clk = 1'b0;
  logic rst, in_vld;
  logic [3:0] opa, opb;
  logic [2:0] op;
  logic [4:0] res;
  logic res_vld;
  int n_run = 0, n_fail = 0;
  logic [4:0] last;

  always #2.5 clk = ~clk;

  nib_alu u0 (.clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
              .op(op), .res(res), .res_vld(res_vld));

  function automatic logic [4:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic [2:0] s);
    case (s)
      3'd0: return {1'b0, a};
      3'd1: return {1'b0, a} + {1'b0, b};
      3'd2: return {1'b0, a} - {1'b0, b};
      3'd3: return (b == 0) ? 5'h1f : 5'({1'b0, a} / {1'b0, b});
      3'd4: return (b == 0) ? {1'b0, a} : 5'({1'b0, a} % {1'b0, b});
      3'd5: return {a, 1'b0};
      3'd6: return {2'b0, a[3:1]};
      default: return (a > b) ? 5'd1 : 5'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] s);
    case (s)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3";
      3'd3: return "R4"; 3'd4: return "R5"; 3'd7: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string r, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [2:0] s);
    in_vld = 1'b1; opa = a; opb = b; op = s;
    @(negedge clk);
    chk(tag(s), {res_vld, res}, {1'b1, model(a, b, s)});
    chk("R8", {5'b0, res_vld}, 6'd1);
    last = res;
  endtask

  task automatic idle(input logic [3:0] a, input logic [3:0] b, input logic [2:0] s);
    in_vld = 1'b0; opa = a; opb = b; op = s;
    @(negedge clk);
    chk("R9", {res_vld, res}, {1'b0, last});
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; in_vld = 1'b0; opa = 4'hf; opb = 4'h3; op = 3'd1;
    @(negedge clk); @(negedge clk);
    chk("R10", {res_vld, res}, 6'd0);
    rst = 1'b0;
    apply(4'd9, 4'd0, 3'd0);
    apply(4'd15, 4'd15, 3'd1);
    apply(4'd3, 4'd9, 3'd2);
    apply(4'd0, 4'd15, 3'd2);
    apply(4'd13, 4'd0, 3'd3);
    apply(4'd14, 4'd4, 3'd3);
    apply(4'd11, 4'd0, 3'd4);
    apply(4'd14, 4'd4, 3'd4);
    apply(4'd15, 4'd2, 3'd5);
    apply(4'd15, 4'd2, 3'd6);
    apply(4'd8, 4'd7, 3'd7);
    apply(4'd7, 4'd7, 3'd7);
    apply(4'd2, 4'd7, 3'd7);
    idle(4'd1, 4'd1, 3'd1);
    idle(4'd5, 4'd0, 3'd3);
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 4) == 0)
        idle(4'($urandom), 4'($urandom), 3'($urandom));
      else
        apply(4'($urandom), 4'($urandom), 3'($urandom));
    end
    in_vld = 1'b1; opa = 4'd6; op = 3'd1; rst = 1'b1;
    @(negedge clk);
    chk("R10", {res_vld, res}, 6'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule